// File: doc/BRIEF.md
# Latency-Insensitive Channel Relay Stage

This block is a clocked stage that is dropped into a long point-to-point channel. Its job is to cut the wire into shorter segments while the channel keeps its latency-insensitive meaning. Each side of the stage carries three signals. A data word and a valid flag move forward: valid high marks a real token, and valid low marks a void token. A stop flag moves backward.

A token that is accepted on the upstream side shows up downstream one clock later. When the downstream side raises stop, the stage holds its output token. It also catches the one token that was already on its way, keeping it in a second, auxiliary slot. Only when both slots are full does the stage raise its own registered stop toward upstream. Because of this, back-pressure never passes through the stage as a combinational path. After reset the stage holds a void token, so a loop of stages starts with one void per stage. The width of the data word is a parameter.

Top module: `lip_relay_stage`

## Requirements
- R1: While reset is high and in the first cycle after it, dn_valid is 0 (void token) and up_stop is 0.
- R2: When up_stop is 0, up_valid is 1, and either dn_stop is 0 or dn_valid is 0 at a clock edge, dn_valid is 1 after that edge and dn_data equals the up_data sampled at that edge (one cycle of latency).
- R3: When the output slot is free to advance (dn_stop is 0 or dn_valid is 0), up_stop is 0 and up_valid is 0 at an edge, dn_valid is 0 after that edge.
- R4: When dn_stop is 1 and dn_valid is 1 at an edge, dn_valid stays 1 and dn_data stays unchanged after that edge.
- R5: A valid token that is accepted (up_valid 1, up_stop 0) while the output is stalled is kept and later delivered. No accepted token is lost.
- R6: up_stop is a registered output. It is 1 only while both slots hold valid tokens, which means dn_valid is 1 whenever up_stop is 1. It rises only in the cycle after an edge at which dn_stop was 1.
- R7: When up_stop is 1 and dn_stop is 0 at an edge, the output slot's token leaves downstream, the auxiliary token moves to the output, dn_valid stays 1, and up_stop drops to 0 after that edge.
- R8: A void token at the input (up_valid 0) is never stored and never makes up_stop rise at the following edge.
- R9: Under any pattern of dn_stop, the sequence of tokens delivered (dn_valid 1 and dn_stop 0 at an edge) equals the sequence of tokens accepted (up_valid 1 and up_stop 0 at an edge), with nothing dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_data | input | DATA_W | Data word from the upstream segment |
| up_valid | input | 1 | Upstream token is real (1) or void (0) |
| up_stop | output | 1 | Registered back-pressure toward upstream |
| dn_data | output | DATA_W | Data word toward the downstream segment |
| dn_valid | output | 1 | Downstream token is real (1) or void (0) |
| dn_stop | input | 1 | Back-pressure from downstream |

## Verification
The bench builds the stage with an 8-bit data word. A narrow word still lets every token carry a distinct sequence tag within each sweep, which makes loss, duplication or reordering visible.

The bench sweeps all 16×16 pairs of four-cycle periodic stop and valid masks. These combinations reach every slot occupancy together with every arrival and release phase. A run with pseudo-random stop and valid adds irregular stall lengths.

Directed sequences cover the cases that need exact timing:
- the one-cycle latency of a token;
- a stall that captures a token already in flight;
- release order, with the output token leaving before the auxiliary one;
- a stall fed only with void tokens.

// File: rtl/lip_rs_pkg.sv
package lip_rs_pkg;

  // Occupancy of the two storage slots of a relay stage
  typedef enum logic [1:0] {
    OCC_NONE = 2'd0,  // output slot holds a void token
    OCC_MAIN = 2'd1,  // output slot holds a real token
    OCC_BOTH = 2'd2   // output and auxiliary slots both hold real tokens
  } occ_e;

endpackage

// File: rtl/lip_slot_reg.sv
module lip_slot_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Data storage needs no reset: validity is tracked by the controller
  always_ff @(posedge clk) begin
    if (ld) q <= d;
  end

endmodule

// File: rtl/lip_rs_ctrl.sv
module lip_rs_ctrl
  import lip_rs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_stop,
  output logic main_ld,
  output logic main_from_aux,
  output logic aux_ld,
  output logic main_v,
  output logic stop_up
);

  occ_e occ_q, occ_d;
  logic take;

  // An input token counts only while upstream is not being held back
  assign take = in_valid && !stop_up;

  always_comb begin
    occ_d         = occ_q;
    main_ld       = 1'b0;
    main_from_aux = 1'b0;
    aux_ld        = 1'b0;
    unique case (occ_q)
      OCC_NONE: begin
        // A void in the output slot can always be replaced
        main_ld = take;
        if (take) occ_d = OCC_MAIN;
      end
      OCC_MAIN: begin
        if (!out_stop) begin
          main_ld = take;
          occ_d   = take ? OCC_MAIN : OCC_NONE;
        end else if (take) begin
          // The token already in flight goes into the auxiliary slot
          aux_ld = 1'b1;
          occ_d  = OCC_BOTH;
        end
      end
      OCC_BOTH: begin
        if (!out_stop) begin
          main_ld       = 1'b1;
          main_from_aux = 1'b1;
          occ_d         = OCC_MAIN;
        end
      end
      default: occ_d = OCC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= OCC_NONE;
      main_v  <= 1'b0;
      stop_up <= 1'b0;
    end else begin
      occ_q   <= occ_d;
      main_v  <= (occ_d != OCC_NONE);
      stop_up <= (occ_d == OCC_BOTH);
    end
  end

  // R8
  // A void input with the auxiliary slot free cannot fill that slot
  void_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && occ_q != OCC_BOTH) |=> (occ_q != OCC_BOTH));

endmodule

// File: rtl/lip_relay_stage.sv
module lip_relay_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_stop,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid,
  input  logic              dn_stop
);

  logic              main_ld, main_from_aux, aux_ld;
  logic [DATA_W-1:0] aux_q, main_d;

  lip_rs_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (up_valid),
    .out_stop     (dn_stop),
    .main_ld      (main_ld),
    .main_from_aux(main_from_aux),
    .aux_ld       (aux_ld),
    .main_v       (dn_valid),
    .stop_up      (up_stop)
  );

  // The output slot loads either fresh input or the parked token
  assign main_d = main_from_aux ? aux_q : up_data;

  lip_slot_reg #(.W(DATA_W)) u_main (
    .clk(clk), .ld(main_ld), .d(main_d), .q(dn_data)
  );

  lip_slot_reg #(.W(DATA_W)) u_aux (
    .clk(clk), .ld(aux_ld), .d(up_data), .q(aux_q)
  );

  // R2
  latency_one_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_stop && (!dn_stop || !dn_valid))
      |=> (dn_valid && dn_data == $past(up_data)));

  // R3
  void_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_valid && !up_stop && (!dn_stop || !dn_valid)) |=> !dn_valid);

  // R4
  hold_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_stop && dn_valid) |=> (dn_valid && $stable(dn_data)));

  // R6
  stop_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    up_stop |-> dn_valid);

  // R6
  stop_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(up_stop) |-> $past(dn_stop));

  // R7
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    (up_stop && !dn_stop) |=> (!up_stop && dn_valid));

  // R8
  void_no_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !$rose(up_stop));

endmodule

// File: tb/test_lip_relay_stage.sv
module test_lip_relay_stage;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] up_data = '0;
  logic          up_valid = 1'b0;
  logic          up_stop;
  logic [DW-1:0] dn_data;
  logic          dn_valid;
  logic          dn_stop = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [DW-1:0] sb[$];
  logic [DW-1:0] tag = '0;

  always #5 clk = ~clk;

  lip_relay_stage #(.DATA_W(DW)) i_lip_relay_stage (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid),
    .up_stop(up_stop), .dn_data(dn_data), .dn_valid(dn_valid),
    .dn_stop(dn_stop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Sits mid-cycle, inputs already driven; records handshakes of the coming edge
  task automatic step();
    if (up_valid && !up_stop) sb.push_back(up_data);
    if (dn_valid && !dn_stop) begin
      if (sb.size() == 0) chk(1'b0, "R9 dup", dn_data, -1);
      else chk(dn_data == sb.pop_front(), "R9 order", dn_data, 0);
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(dn_valid == 1'b0 && up_stop == 1'b0, "R1 in reset", {dn_valid, up_stop}, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(dn_valid == 1'b0 && up_stop == 1'b0, "R1 after reset", {dn_valid, up_stop}, 0);

    // R2 latency, then R3 void output
    up_valid = 1; up_data = 8'h5A; dn_stop = 0;
    step();
    up_valid = 0;
    chk(dn_valid && dn_data == 8'h5A, "R2 latency", dn_data, 8'h5A);
    step();
    chk(!dn_valid, "R3 void out", dn_valid, 0);

    // R4/R5/R6/R7 stall with in-flight token
    up_valid = 1; up_data = 8'hA1; dn_stop = 0;
    step();
    up_data = 8'hB2; dn_stop = 1;
    chk(dn_valid && dn_data == 8'hA1, "R2 first token", dn_data, 8'hA1);
    step();
    up_data = 8'hC3;
    chk(up_stop == 1'b1, "R6 stop when full", up_stop, 1);
    chk(dn_valid && dn_data == 8'hA1, "R4 hold", dn_data, 8'hA1);
    step();
    dn_stop = 0;
    chk(up_stop && dn_data == 8'hA1, "R4 hold 2", dn_data, 8'hA1);
    step();
    chk(dn_valid && dn_data == 8'hB2, "R7 aux next R5", dn_data, 8'hB2);
    chk(!up_stop, "R7 stop drops", up_stop, 0);
    step();
    up_valid = 0;
    chk(dn_valid && dn_data == 8'hC3, "R5 held input", dn_data, 8'hC3);
    step();
    chk(!dn_valid, "R3 drained", dn_valid, 0);

    // R8 stall fed with voids only
    up_valid = 1; up_data = 8'h77;
    step();
    up_valid = 0; dn_stop = 1;
    step();
    chk(!up_stop, "R8 void no stop", up_stop, 0);
    step();
    chk(!up_stop && dn_data == 8'h77, "R8 void no stop 2", dn_data, 8'h77);
    dn_stop = 0;
    step();
    chk(!dn_valid, "R8 void not stored", dn_valid, 0);
    chk(sb.size() == 0, "R9 directed balance", sb.size(), 0);

    // R9 sweep over periodic stop and valid masks
    for (int sm = 0; sm < 16; sm++) begin
      for (int vm = 0; vm < 16; vm++) begin
        for (int k = 0; k < 24; k++) begin
          dn_stop = sm[k % 4];
          if (!(up_valid && up_stop)) begin
            up_valid = vm[(k + 1) % 4];
            if (up_valid) begin tag++; up_data = tag; end
          end
          step();
        end
        up_valid = 0; dn_stop = 0;
        for (int k = 0; k < 4; k++) step();
        chk(sb.size() == 0 && !dn_valid, "R9 sweep drain", sb.size(), 0);
      end
    end

    // R9 pseudo-random run
    for (int k = 0; k < 3000; k++) begin
      dn_stop = ($urandom % 3) == 0;
      if (!(up_valid && up_stop)) begin
        up_valid = ($urandom % 4) != 0;
        if (up_valid) begin tag++; up_data = tag; end
      end
      step();
    end
    up_valid = 0; dn_stop = 0;
    for (int k = 0; k < 4; k++) step();
    chk(sb.size() == 0, "R9 random drain", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule